// File: doc/BRIEF.md
# Single-bit Hamming ECC checker-corrector

This block takes the 22-bit error-correcting code recomputed over a 256-byte chunk of flash data and the 22-bit code read back from the spare area, and decides what happened to the chunk. It reports one of four verdicts:

- the chunk is clean;
- the stored code itself took a hit;
- a single data bit flipped, with the byte offset and bit index needed to repair it;
- the damage cannot be repaired.

A buffer controller uses the location to flip the bad bit in place. It uses the uncorrectable verdict to discard the chunk.

Each code holds a parity set in its low 11 bits and the complementary parity set in its high 11 bits. The syndrome is the XOR of the two codes. A registered adder tree takes the population count of the syndrome, and the verdict follows from that count together with a check that the two halves of the syndrome are complements of each other. For a 512-byte page a single start checks both chunks back to back, each with its own code pair. Offsets in the second chunk are reported plus 256.

Top module: `ecc_hamming_chk`

## Requirements
- R1: Bits 10:0 of each code are the parity set and bits 21:11 the complementary set. The syndrome is computed code XOR stored code, and a zero syndrome gives verdict 2'b00 (clean).
- R2: When either code is all zero, the verdict is 2'b00, whatever the other code holds.
- R3: A syndrome with exactly one bit set gives verdict 2'b10 (stored code damaged). Whenever the verdict is not 2'b01, byte_o and bit_o are zero.
- R4: A syndrome with exactly 11 bits set, whose low half XOR high half equals 11'h7FF, gives verdict 2'b01 (corrected). bit_o is syndrome bits 2:0 and byte_o is syndrome bits 10:3.
- R5: A syndrome with 11 bits set whose halves are not complementary gives verdict 2'b11 (uncorrectable).
- R6: Any other nonzero syndrome, with both codes nonzero, gives verdict 2'b11.
- R7: done_o is high for exactly one cycle per checked chunk, three cycles after the cycle in which start_i is accepted. The verdict and location are valid in that cycle.
- R8: With page512_i high at the accepted start, a second result follows in the next cycle with chunk_o=1. It is computed from calc1_i/stored1_i as sampled at the start, and a corrected byte offset has 256 added (byte_o bit 8 set).
- R9: A start_i in the cycle right after an accepted 512-byte start is ignored and produces no result.
- R10: During and after reset, done_o, verdict_o, chunk_o, byte_o and bit_o are zero.
- R11: With page512_i low, one start gives one result with chunk_o=0. Starts in consecutive cycles each give their own result, in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a check with the codes present this cycle |
| page512_i | input | 1 | 1: check two chunks, 0: one chunk |
| calc0_i | input | 22 | Recomputed code, first chunk |
| stored0_i | input | 22 | Stored code, first chunk |
| calc1_i | input | 22 | Recomputed code, second chunk |
| stored1_i | input | 22 | Stored code, second chunk |
| done_o | output | 1 | Result valid pulse |
| verdict_o | output | 2 | 00 clean, 01 corrected, 10 code damaged, 11 uncorrectable |
| chunk_o | output | 1 | Chunk the result belongs to |
| byte_o | output | 9 | Failing byte offset within the page |
| bit_o | output | 3 | Failing bit index within the byte |

## Verification
The bench feeds the following code pairs:

- equal codes;
- pairs with one side zero;
- single-bit syndromes;
- true one-bit data errors built as a position and its complement, including positions 0 and 0x7FF;
- 11-bit syndromes whose halves are not complementary;
- 2-bit and 12-bit syndromes.

Together these separate the zero rule, the count-of-one rule, the count-of-eleven rule and the complement check from one another. Two-chunk starts with correctable errors in both halves show the 256 offset and the one-cycle spacing. A start held high across the second-chunk cycle and a stream of single-chunk starts show the ignore rule and ordering under full throughput.

// File: rtl/ecc_chk_pkg.sv
package ecc_chk_pkg;
  localparam int PAR_W_DEF = 11;
  localparam int BIT_W_DEF = 3;
  localparam int GRP_W_DEF = 6;

  typedef enum logic [1:0] {
    VERD_NONE  = 2'b00,
    VERD_FIXED = 2'b01,
    VERD_FIELD = 2'b10,
    VERD_FATAL = 2'b11
  } verdict_e;
endpackage

// File: rtl/ecc_syn_stage.sv
module ecc_syn_stage #(
  parameter int PAR_W = 11
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               vld_i,
  input  logic               chunk_i,
  input  logic [2*PAR_W-1:0] calc_i,
  input  logic [2*PAR_W-1:0] stored_i,
  output logic               vld_o,
  output logic               chunk_o,
  output logic [2*PAR_W-1:0] syn_o,
  output logic               zero_o,
  output logic               half_ok_o
);
  localparam int CODE_W = 2 * PAR_W;

  logic [CODE_W-1:0] syn;
  logic [PAR_W-1:0]  half_diff;

  always_comb begin
    syn       = calc_i ^ stored_i;
    half_diff = calc_i[PAR_W-1:0] ^ calc_i[CODE_W-1:PAR_W]
              ^ stored_i[PAR_W-1:0] ^ stored_i[CODE_W-1:PAR_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o     <= 1'b0;
      chunk_o   <= 1'b0;
      syn_o     <= '0;
      zero_o    <= 1'b0;
      half_ok_o <= 1'b0;
    end else begin
      vld_o <= vld_i;
      if (vld_i) begin
        chunk_o   <= chunk_i;
        syn_o     <= syn;
        zero_o    <= (syn == '0) || (calc_i == '0) || (stored_i == '0);
        half_ok_o <= &half_diff;
      end
    end
  end
endmodule

// File: rtl/ecc_pop_tree.sv
// First adder-tree level: registered per-group bit counts.
module ecc_pop_tree #(
  parameter int IN_W   = 22,
  parameter int GRP_W  = 6,
  parameter int NGRP   = (IN_W + GRP_W - 1) / GRP_W,
  parameter int GCNT_W = $clog2(GRP_W + 1)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [IN_W-1:0]             in_i,
  output logic [NGRP-1:0][GCNT_W-1:0] grp_cnt_o
);
  localparam int PAD_W = NGRP * GRP_W;

  logic [PAD_W-1:0] padded;
  assign padded = PAD_W'(in_i);

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    logic [GCNT_W-1:0] cnt;
    always_comb begin
      cnt = '0;
      for (int b = 0; b < GRP_W; b++) cnt = cnt + GCNT_W'(padded[g*GRP_W+b]);
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) grp_cnt_o[g] <= '0;
      else         grp_cnt_o[g] <= cnt;
    end
  end
endmodule

// File: rtl/ecc_classify.sv
module ecc_classify
  import ecc_chk_pkg::*;
#(
  parameter int PAR_W  = 11,
  parameter int BIT_W  = 3,
  parameter int NGRP   = 4,
  parameter int GCNT_W = 3
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        vld_i,
  input  logic                        chunk_i,
  input  logic                        zero_i,
  input  logic                        half_ok_i,
  input  logic [PAR_W-1:0]            lo_i,
  input  logic [NGRP-1:0][GCNT_W-1:0] grp_cnt_i,
  output logic                        done_o,
  output logic [1:0]                  verdict_o,
  output logic                        chunk_o,
  output logic [PAR_W-BIT_W:0]        byte_o,
  output logic [BIT_W-1:0]            bit_o
);
  localparam int BYTE_W = PAR_W - BIT_W;
  localparam int PCNT_W = $clog2(2 * PAR_W + 1);

  logic [PCNT_W-1:0] total;
  verdict_e          verd;

  always_comb begin
    total = '0;
    for (int g = 0; g < NGRP; g++) total = total + PCNT_W'(grp_cnt_i[g]);
  end

  always_comb begin
    if (zero_i)                                       verd = VERD_NONE;
    else if (total == PCNT_W'(1))                     verd = VERD_FIELD;
    else if (total == PCNT_W'(PAR_W) && half_ok_i)    verd = VERD_FIXED;
    else                                              verd = VERD_FATAL;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o    <= 1'b0;
      verdict_o <= 2'b00;
      chunk_o   <= 1'b0;
      byte_o    <= '0;
      bit_o     <= '0;
    end else begin
      done_o <= vld_i;
      if (vld_i) begin
        verdict_o <= verd;
        chunk_o   <= chunk_i;
        if (verd == VERD_FIXED) begin
          byte_o <= {chunk_i, lo_i[PAR_W-1:BIT_W]};
          bit_o  <= lo_i[BIT_W-1:0];
        end else begin
          byte_o <= '0;
          bit_o  <= '0;
        end
      end
    end
  end

  assert_loc_clear_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && verdict_o != VERD_FIXED |-> byte_o == '0 && bit_o == '0);

  assert_fix_needs_halves_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && verdict_o == VERD_FIXED |-> $past(half_ok_i));

  assert_chunk1_offset_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && chunk_o && verdict_o == VERD_FIXED |-> byte_o[BYTE_W]);
endmodule

// File: rtl/ecc_hamming_chk.sv
module ecc_hamming_chk
  import ecc_chk_pkg::*;
#(
  parameter int PAR_W = PAR_W_DEF,
  parameter int BIT_W = BIT_W_DEF,
  parameter int GRP_W = GRP_W_DEF
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic                 page512_i,
  input  logic [2*PAR_W-1:0]   calc0_i,
  input  logic [2*PAR_W-1:0]   stored0_i,
  input  logic [2*PAR_W-1:0]   calc1_i,
  input  logic [2*PAR_W-1:0]   stored1_i,
  output logic                 done_o,
  output logic [1:0]           verdict_o,
  output logic                 chunk_o,
  output logic [PAR_W-BIT_W:0] byte_o,
  output logic [BIT_W-1:0]     bit_o
);
  localparam int CODE_W = 2 * PAR_W;
  localparam int NGRP   = (CODE_W + GRP_W - 1) / GRP_W;
  localparam int GCNT_W = $clog2(GRP_W + 1);

  // chunk sequencer: second chunk issued one cycle after an accepted 512 start
  logic              pend_q, accept;
  logic [CODE_W-1:0] c1_calc_q, c1_stored_q;
  logic              feed_vld, feed_chunk;
  logic [CODE_W-1:0] feed_calc, feed_stored;

  assign accept      = start_i && !pend_q;
  assign feed_vld    = accept || pend_q;
  assign feed_chunk  = pend_q;
  assign feed_calc   = pend_q ? c1_calc_q   : calc0_i;
  assign feed_stored = pend_q ? c1_stored_q : stored0_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q      <= 1'b0;
      c1_calc_q   <= '0;
      c1_stored_q <= '0;
    end else begin
      pend_q <= accept && page512_i;
      if (accept && page512_i) begin
        c1_calc_q   <= calc1_i;
        c1_stored_q <= stored1_i;
      end
    end
  end

  logic              s1_vld, s1_chunk, s1_zero, s1_half;
  logic [CODE_W-1:0] s1_syn;

  ecc_syn_stage #(.PAR_W(PAR_W)) u_syn (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .vld_i    (feed_vld),
    .chunk_i  (feed_chunk),
    .calc_i   (feed_calc),
    .stored_i (feed_stored),
    .vld_o    (s1_vld),
    .chunk_o  (s1_chunk),
    .syn_o    (s1_syn),
    .zero_o   (s1_zero),
    .half_ok_o(s1_half)
  );

  logic [NGRP-1:0][GCNT_W-1:0] s2_cnt;

  ecc_pop_tree #(.IN_W(CODE_W), .GRP_W(GRP_W), .NGRP(NGRP), .GCNT_W(GCNT_W)) u_pop (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .in_i     (s1_syn),
    .grp_cnt_o(s2_cnt)
  );

  logic             s2_vld, s2_chunk, s2_zero, s2_half;
  logic [PAR_W-1:0] s2_lo;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s2_vld   <= 1'b0;
      s2_chunk <= 1'b0;
      s2_zero  <= 1'b0;
      s2_half  <= 1'b0;
      s2_lo    <= '0;
    end else begin
      s2_vld   <= s1_vld;
      s2_chunk <= s1_chunk;
      s2_zero  <= s1_zero;
      s2_half  <= s1_half;
      s2_lo    <= s1_syn[PAR_W-1:0];
    end
  end

  ecc_classify #(.PAR_W(PAR_W), .BIT_W(BIT_W), .NGRP(NGRP), .GCNT_W(GCNT_W)) u_cls (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .vld_i    (s2_vld),
    .chunk_i  (s2_chunk),
    .zero_i   (s2_zero),
    .half_ok_i(s2_half),
    .lo_i     (s2_lo),
    .grp_cnt_i(s2_cnt),
    .done_o   (done_o),
    .verdict_o(verdict_o),
    .chunk_o  (chunk_o),
    .byte_o   (byte_o),
    .bit_o    (bit_o)
  );

  assert_done_latency_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |-> ##3 (done_o && !chunk_o));

  assert_second_follows_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && chunk_o |-> $past(done_o) && !$past(chunk_o));

  assert_pending_blocks_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q |-> ##3 (done_o && chunk_o));
endmodule

// File: tb/ecc_hamming_chk_tb.sv
module ecc_hamming_chk_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, p512 = 1'b0;
  logic [21:0] c0 = '0, s0 = '0, c1 = '0, s1 = '0;
  logic        done, chunk;
  logic [1:0]  verdict;
  logic [8:0]  byte_off;
  logic [2:0]  bit_idx;

  always #2ns clk = ~clk;

  ecc_hamming_chk u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .page512_i(p512),
    .calc0_i(c0), .stored0_i(s0), .calc1_i(c1), .stored1_i(s1),
    .done_o(done), .verdict_o(verdict), .chunk_o(chunk),
    .byte_o(byte_off), .bit_o(bit_idx)
  );

  int total = 0, bad = 0, cyc = 0;
  bit finished = 0;
  int    due_q[$], verd_q[$], byte_q[$], bit_q[$], chk_q[$];
  string tag_q[$];
  bit    m_pend = 0;

  localparam logic [21:0] BASE = 22'h2C3A91;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [21:0] flip(input logic [10:0] p);
    return {~p, p};
  endfunction

  function automatic void model(input logic [21:0] c, input logic [21:0] s, input int ch,
                                output int v, output int by, output int bi);
    logic [21:0] syn = c ^ s;
    int pc = $countones(syn);
    by = 0; bi = 0;
    if (syn == 0 || c == 0 || s == 0) v = 0;
    else if (pc == 1) v = 2;
    else if (pc == 11 && ((syn[10:0] ^ syn[21:11]) == 11'h7FF)) begin
      v = 1; by = int'(syn[10:3]) + (ch != 0 ? 256 : 0); bi = int'(syn[2:0]);
    end else v = 3;
  endfunction

  task automatic push(input int due, input logic [21:0] c, input logic [21:0] s,
                      input int ch, input string tag);
    int v, by, bi;
    model(c, s, ch, v, by, bi);
    due_q.push_back(due); verd_q.push_back(v); byte_q.push_back(by);
    bit_q.push_back(bi); chk_q.push_back(ch); tag_q.push_back(tag);
  endtask

  task automatic step(input bit st, input logic [21:0] a0, input logic [21:0] b0,
                      input logic [21:0] a1, input logic [21:0] b1, input bit pg, input string tag);
    @(negedge clk);
    start = st; p512 = pg; c0 = a0; s0 = b0; c1 = a1; s1 = b1;
    if (st && !m_pend) begin
      push(cyc + 3, a0, b0, 0, tag);
      if (pg) push(cyc + 4, a1, b1, 1, tag);
      m_pend = pg;
    end else m_pend = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, '0, '0, '0, '0, 0, "idle");
  endtask

  task automatic one(input logic [21:0] a, input logic [21:0] b, input string tag);
    step(1, a, b, '0, '0, 0, tag);
    idle(5);
  endtask

  // reference comparison every cycle
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (due_q.size() > 0 && due_q[0] == cyc) begin
        total++;
        if (!(done && verdict == 2'(verd_q[0]) && int'(byte_off) == byte_q[0] &&
              int'(bit_idx) == bit_q[0] && int'(chunk) == chk_q[0])) begin
          bad++;
          $display("FAIL %s cyc=%0d: got done=%0b v=%0d byte=%0d bit=%0d chunk=%0b exp v=%0d byte=%0d bit=%0d chunk=%0d",
                   tag_q[0], cyc, done, verdict, byte_off, bit_idx, chunk,
                   verd_q[0], byte_q[0], bit_q[0], chk_q[0]);
        end
        void'(due_q.pop_front()); void'(verd_q.pop_front()); void'(byte_q.pop_front());
        void'(bit_q.pop_front()); void'(chk_q.pop_front()); void'(tag_q.pop_front());
      end else begin
        total++;
        if (done) begin
          bad++;
          $display("FAIL R7/R9 cyc=%0d: got done=1 exp done=0", cyc);
        end
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    total++; // R10 reset state
    if (done || verdict != 0 || chunk || byte_off != 0 || bit_idx != 0) begin
      bad++;
      $display("FAIL R10: got done=%0b v=%0d chunk=%0b byte=%0d bit=%0d exp all 0",
               done, verdict, chunk, byte_off, bit_idx);
    end
    rst_n = 1'b1;
    idle(2);

    one(BASE, BASE, "R1");
    one(22'h0, BASE, "R2");
    one(BASE, 22'h0, "R2");
    one(BASE, BASE ^ (22'h1 << 17), "R3");
    one(BASE, BASE ^ 22'h1, "R3");
    one(BASE, BASE ^ flip(11'h2A5), "R4");
    one(BASE, BASE ^ flip(11'h7FF), "R4");
    one(BASE, BASE ^ flip(11'h000), "R4");
    one(BASE, BASE ^ (22'h3FF | 22'h800), "R5");
    one(BASE, BASE ^ 22'h000003, "R6");
    one(BASE, BASE ^ 22'h3FFC00, "R6");

    step(1, BASE, BASE ^ flip(11'h005), 22'h155AA3, 22'h155AA3 ^ flip(11'h100), 1, "R8");
    idle(6);
    step(1, BASE, BASE ^ 22'h10, 22'h3, 22'h3 ^ flip(11'h3C1), 1, "R9");
    step(1, BASE, BASE ^ flip(11'h0F0), 22'h7, 22'h7, 1, "R9");
    idle(6);

    step(1, BASE, BASE ^ flip(11'h111), '0, '0, 0, "R11");
    step(1, BASE, BASE, '0, '0, 0, "R11");
    step(1, BASE, BASE ^ 22'h40, '0, '0, 0, "R11");
    idle(8);

    total++;
    if (due_q.size() != 0) begin
      bad++;
      $display("FAIL R7: got %0d results missing exp 0", due_q.size());
    end
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #40us;
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog: got hang exp completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule